// File: doc/BRIEF.md
# Platform Status and Control Register Block

This block is the software-visible face of a small system controller. It hangs off a simple 32-bit register bus carrying an address, separate read and write strobes, a byte count for the access and write data, and it returns registered read data one cycle after a read strobe. Software uses it to discover how the platform was built, to see whether the memory and the serial links are up, to read back the clock generator settings, and to ask for a whole-system reset.

The clock generator, memory controller and links are not part of this block. Their live values come in as input ports: the timer clock frequency in MHz, the memory size in GiB and one "link up" bit per link. Fixed build facts are parameters. Only the low 16 address bits are decoded, and only full 4-byte accesses do anything. Read-only registers discard writes. Offsets outside the defined map read as zero and ignore writes, and an optional sticky flag records that such an access happened.

Writing the soft-reset register with bit 4 set produces a registered request pulse exactly one clock wide on the cycle after the write.

Top module: `plat_ctl_regs`

## Requirements
- R1: After reset, `bus_rdata`, `sys_rst_req` and `undef_seen` are all 0.
- R2: `bus_size` carries the access width in bytes, and only the value 4 is a full access. A read of any other size returns 0. A write of any other size changes nothing and raises no reset request.
- R3: Only `bus_addr[15:0]` is decoded, so the upper address bits are ignored. The defined word offsets that have no live content read 0 and do not set `undef_seen`. These are 0x00, 0x04, 0x08 (identity), 0x0C, 0x10, 0x1C, 0x20 to 0x2C, 0x3C to 0x44 and 0x48.
- R4: Offset 0x14 (memory status) reads 0x0000_0005: bit 0 means locked and bit 2 means calibrated.
- R5: Offset 0x30 (clock settings) reads {clock-1 divide = 1 in bits 31:24, multiplier = 1 in bits 23:16, `timer_mhz` in bits 15:8, clock-0 divide = 1 in bits 7:0}.
- R6: Offset 0x34 (build options) reads 0x0000_000E with the default three links. Bit 0 is coherence-unit present (clear), and bits 1 to 3 mean link 0 to link 2 enabled.
- R7: Offset 0x38 (memory config) reads `mem_gib[3:0]` in bits 3:0 and 0xFFF in bits 15:4, with all other bits 0. `mem_gib` must stay below 16.
- R8: Offset 0x18 (link status) reads `link_up[i]` at bit 8*i. All other bits are 0.
- R9: Full writes to offsets 0x00, 0x04, 0x08, 0x14, 0x18, 0x30, 0x34 and 0x38 are discarded, so a later read returns the same value as before.
- R10: A full write to offset 0x10 with bit 4 set drives `sys_rst_req` high for exactly one cycle, starting the cycle after the write. With bit 4 clear, no pulse is produced. A request that arrives while the pulse is already high is merged into it.
- R11: An offset that is not word aligned, or is above 0x48, reads 0 and ignores writes. A full-size access to such an offset sets `undef_seen`, which stays set until reset.
- R12: `bus_rdata` carries the value for a read strobe on the following cycle, and is 0 in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_size | input | 3 | Access width in bytes (4 = full word) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| timer_mhz | input | 8 | Timer clock frequency in MHz |
| mem_gib | input | 8 | Installed memory in GiB (below 16) |
| link_up | input | 3 | Per-link locked status |
| sys_rst_req | output | 1 | One-cycle system reset request |
| undef_seen | output | 1 | Sticky undefined-access flag |

## Verification
The hardest situations to reach from the ports are the ones where nothing should happen. Examples are a partial-size write carrying bit 4 to the soft-reset offset, an aliased address whose upper bits are non-zero, and an unaligned offset that falls inside the defined range. Random stimulus therefore draws sizes 1, 2 and 4, offsets across and beyond the map including unaligned ones, and random upper address bits. The bench model tracks the expected reset pulse and the sticky flag after every access. Directed cases first pin down the sticky flag, the read-only discards and the pulse timing before random traffic can mask them.

// File: rtl/plat_regs_pkg.sv
package plat_regs_pkg;

   localparam int unsigned DW       = 32;
   localparam int unsigned OFS_W    = 16;
   localparam int unsigned FULL_SZ  = 4;

   localparam logic [OFS_W-1:0] OFS_SOFTRST  = 16'h0010;
   localparam logic [OFS_W-1:0] OFS_MEMSTAT  = 16'h0014;
   localparam logic [OFS_W-1:0] OFS_LINKSTAT = 16'h0018;
   localparam logic [OFS_W-1:0] OFS_CLKSET   = 16'h0030;
   localparam logic [OFS_W-1:0] OFS_BUILD    = 16'h0034;
   localparam logic [OFS_W-1:0] OFS_MEMCFG   = 16'h0038;
   localparam logic [OFS_W-1:0] OFS_LAST     = 16'h0048;

   typedef enum logic [3:0] {
      SEL_ZERO,
      SEL_SOFTRST,
      SEL_MEMSTAT,
      SEL_LINKSTAT,
      SEL_CLKSET,
      SEL_BUILD,
      SEL_MEMCFG,
      SEL_UNDEF
   } reg_sel_e;

endpackage

// File: rtl/plat_addr_decode.sv
module plat_addr_decode
   import plat_regs_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        size,
   output reg_sel_e          sel,
   output logic              full
);

   generate
      if (ADDR_W < OFS_W) begin : g_bad_addr
         $error("plat_addr_decode: ADDR_W must be at least 16");
      end
   endgenerate

   logic [OFS_W-1:0] ofs;
   logic             unused_hi;

   assign ofs       = addr[OFS_W-1:0];
   assign unused_hi = ^addr;
   assign full      = (size == 3'(FULL_SZ));

   always_comb begin
      if ((ofs[1:0] != 2'b00) || (ofs > OFS_LAST)) begin
         sel = SEL_UNDEF;
      end else begin
         unique case (ofs)
            OFS_SOFTRST:  sel = SEL_SOFTRST;
            OFS_MEMSTAT:  sel = SEL_MEMSTAT;
            OFS_LINKSTAT: sel = SEL_LINKSTAT;
            OFS_CLKSET:   sel = SEL_CLKSET;
            OFS_BUILD:    sel = SEL_BUILD;
            OFS_MEMCFG:   sel = SEL_MEMCFG;
            default:      sel = SEL_ZERO;
         endcase
      end
   end

endmodule

// File: rtl/plat_rd_mux.sv
module plat_rd_mux
   import plat_regs_pkg::*;
#(
   parameter int unsigned NUM_LINKS   = 3,
   parameter int unsigned LINK_STRIDE = 8,
   parameter int unsigned MEM_W       = 8,
   parameter bit          IOCU_EN     = 1'b0,
   parameter logic [7:0]  CLK0_DIV    = 8'd1,
   parameter logic [7:0]  CLK_MUL     = 8'd1,
   parameter logic [7:0]  CLK1_DIV    = 8'd1
) (
   input  reg_sel_e             sel,
   input  logic [7:0]           timer_mhz,
   input  logic [MEM_W-1:0]     mem_gib,
   input  logic [NUM_LINKS-1:0] link_up,
   output logic [DW-1:0]        word
);

   localparam int unsigned MEMSZ_W   = 4;
   localparam int unsigned MHZ_W     = 12;
   localparam int unsigned LINKS_W   = NUM_LINKS * LINK_STRIDE;
   localparam int unsigned BUILD_W   = NUM_LINKS + 1;

   generate
      if (LINKS_W > DW) begin : g_bad_links
         $error("plat_rd_mux: links do not fit the status word");
      end
      if (MEM_W < MEMSZ_W) begin : g_bad_mem
         $error("plat_rd_mux: MEM_W must be at least 4");
      end
   endgenerate

   logic [NUM_LINKS-1:0][LINK_STRIDE-1:0] link_lanes;
   logic [BUILD_W-1:0]                    build_bits;
   logic [DW-1:0] memstat_w, linkstat_w, clkset_w, build_w, memcfg_w;
   logic          unused_mem;

   assign build_bits[0] = IOCU_EN;

   genvar g;
   generate
      for (g = 0; g < NUM_LINKS; g++) begin : g_link
         assign link_lanes[g]     = {{(LINK_STRIDE-1){1'b0}}, link_up[g]};
         assign build_bits[g + 1] = 1'b1;
      end
   endgenerate

   assign unused_mem = ^mem_gib;
   assign memstat_w  = 32'h0000_0005;
   assign linkstat_w = {{(DW-LINKS_W){1'b0}}, link_lanes};
   assign clkset_w   = {CLK1_DIV, CLK_MUL, timer_mhz, CLK0_DIV};
   assign build_w    = {{(DW-BUILD_W){1'b0}}, build_bits};
   assign memcfg_w   = {{(DW-MHZ_W-MEMSZ_W){1'b0}}, {MHZ_W{1'b1}}, mem_gib[MEMSZ_W-1:0]};

   always_comb begin
      unique case (sel)
         SEL_MEMSTAT:  word = memstat_w;
         SEL_LINKSTAT: word = linkstat_w;
         SEL_CLKSET:   word = clkset_w;
         SEL_BUILD:    word = build_w;
         SEL_MEMCFG:   word = memcfg_w;
         default:      word = '0;
      endcase
   end

endmodule

// File: rtl/plat_rst_pulse.sv
module plat_rst_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic req
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req <= 1'b0;
      end else begin
         req <= fire && !req;
      end
   end

   // R10: the request never lasts longer than one cycle
   a_r10_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> !req);

endmodule

// File: rtl/plat_ctl_regs.sv
module plat_ctl_regs
   import plat_regs_pkg::*;
#(
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned NUM_LINKS      = 3,
   parameter int unsigned LINK_STRIDE    = 8,
   parameter int unsigned MEM_W          = 8,
   parameter int unsigned RST_BIT        = 4,
   parameter bit          IOCU_EN        = 1'b0,
   parameter bit          HAS_UNDEF_FLAG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_rd,
   input  logic                 bus_wr,
   input  logic [2:0]           bus_size,
   input  logic [DW-1:0]        bus_wdata,
   output logic [DW-1:0]        bus_rdata,
   input  logic [7:0]           timer_mhz,
   input  logic [MEM_W-1:0]     mem_gib,
   input  logic [NUM_LINKS-1:0] link_up,
   output logic                 sys_rst_req,
   output logic                 undef_seen
);

   generate
      if (RST_BIT >= DW) begin : g_bad_rstbit
         $error("plat_ctl_regs: RST_BIT outside the data word");
      end
   endgenerate

   reg_sel_e      sel;
   logic          full;
   logic [DW-1:0] rd_word;
   logic          fire;
   logic          unused_wdata;

   plat_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .size (bus_size),
      .sel  (sel),
      .full (full)
   );

   plat_rd_mux #(
      .NUM_LINKS   (NUM_LINKS),
      .LINK_STRIDE (LINK_STRIDE),
      .MEM_W       (MEM_W),
      .IOCU_EN     (IOCU_EN)
   ) u_mux (
      .sel       (sel),
      .timer_mhz (timer_mhz),
      .mem_gib   (mem_gib),
      .link_up   (link_up),
      .word      (rd_word)
   );

   assign fire         = bus_wr && full && (sel == SEL_SOFTRST) && bus_wdata[RST_BIT];
   assign unused_wdata = ^bus_wdata;

   plat_rst_pulse u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .req   (sys_rst_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else begin
         bus_rdata <= (bus_rd && full) ? rd_word : '0;
      end
   end

   generate
      if (HAS_UNDEF_FLAG) begin : g_undef
         logic seen_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               seen_q <= 1'b0;
            end else if ((bus_rd || bus_wr) && full && (sel == SEL_UNDEF)) begin
               seen_q <= 1'b1;
            end
         end
         assign undef_seen = seen_q;

         // R11: the flag is sticky until reset
         a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            undef_seen |=> undef_seen);
      end else begin : g_no_undef
         assign undef_seen = 1'b0;
      end
   endgenerate

   // R10: a pulse is always caused by a full write of the reset bit to 0x10
   a_r10_cause: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |-> $past(bus_wr && bus_size == 3'd4 &&
                            bus_addr[15:0] == 16'h0010 && bus_wdata[RST_BIT]));

   // R2: a partial write never requests a reset
   a_r2_partial_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_size != 3'd4) |=> !sys_rst_req);

   // R2: a partial read returns zero
   a_r2_partial_rd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_size != 3'd4) |=> bus_rdata == '0);

   // R12: no read, no data
   a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> bus_rdata == '0);

   // R4: memory status reads locked and calibrated
   a_r4_memstat: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_size == 3'd4 && bus_addr[15:0] == 16'h0014) |=>
         bus_rdata == 32'h0000_0005);

   // R7: the memory size must fit its 4-bit field
   a_r7_mem_fits: assert property (@(posedge clk) disable iff (!rst_n)
      mem_gib < MEM_W'(16));

endmodule

// File: tb/sim_plat_ctl_regs.sv
module sim_plat_ctl_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_size = 3'd4;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  timer_mhz = 8'd50;
   logic [7:0]  mem_gib = 8'd1;
   logic [2:0]  link_up = 3'b000;
   logic        sys_rst_req;
   logic        undef_seen;

   int  vectors = 0;
   int  fails = 0;
   bit  done = 1'b0;
   bit  exp_seen = 1'b0;

   always #10 clk = ~clk;

   plat_ctl_regs u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .timer_mhz(timer_mhz), .mem_gib(mem_gib),
      .link_up(link_up), .sys_rst_req(sys_rst_req), .undef_seen(undef_seen)
   );

   function automatic bit is_undef(input logic [31:0] a);
      return (a[1:0] != 2'b00) || (a[15:0] > 16'h0048);
   endfunction

   function automatic logic [31:0] exp_read(input logic [31:0] a, input logic [2:0] sz);
      if (sz != 3'd4 || is_undef(a)) return 32'h0;
      case (a[15:0])
         16'h0014: return 32'h0000_0005;
         16'h0018: return {15'h0, link_up[2], 7'h0, link_up[1], 7'h0, link_up[0]};
         16'h0030: return {8'd1, 8'd1, timer_mhz, 8'd1};
         16'h0034: return 32'h0000_000E;
         16'h0038: return {16'h0, 12'hFFF, mem_gib[3:0]};
         default:  return 32'h0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_read(input string req, input logic [31:0] a, input logic [2:0] sz);
      bus_addr = a; bus_size = sz; bus_rd = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_rd = 1'b0;
      check(req, bus_rdata, exp_read(a, sz));
      if (sz == 3'd4 && is_undef(a)) exp_seen = 1'b1;
      check({req, " flag"}, {31'h0, undef_seen}, {31'h0, exp_seen});
   endtask

   task automatic do_write(input string req, input logic [31:0] a, input logic [2:0] sz,
                           input logic [31:0] d);
      bit fire;
      fire = (sz == 3'd4) && (a[15:0] == 16'h0010) && d[4];
      bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
      check({req, " pulse"}, {31'h0, sys_rst_req}, {31'h0, fire});
      @(posedge clk); @(negedge clk);
      check({req, " pulse end"}, {31'h0, sys_rst_req}, 32'h0);
      if (sz == 3'd4 && is_undef(a)) exp_seen = 1'b1;
      check({req, " flag"}, {31'h0, undef_seen}, {31'h0, exp_seen});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      logic [2:0] sizes [3];
      sizes[0] = 3'd1; sizes[1] = 3'd2; sizes[2] = 3'd4;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 rdata", bus_rdata, 32'h0);
      check("R1 req", {31'h0, sys_rst_req}, 32'h0);
      check("R1 flag", {31'h0, undef_seen}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 zero registers and upper-bit aliasing
      for (int o = 0; o <= 'h48; o += 4) begin
         if (!(o inside {'h14, 'h18, 'h30, 'h34, 'h38}))
            do_read("R3 zero reg", 32'(o), 3'd4);
      end
      do_read("R3 alias memstat", 32'hABCD_0014, 3'd4);
      do_read("R4 memstat", 32'h0000_0014, 3'd4);
      // R5 clock settings
      timer_mhz = 8'd100;
      do_read("R5 clkset", 32'h30, 3'd4);
      do_read("R6 build", 32'h34, 3'd4);
      // R7 memory config 1 and 2 GiB
      mem_gib = 8'd1; do_read("R7 memcfg 1GiB", 32'h38, 3'd4);
      mem_gib = 8'd2; do_read("R7 memcfg 2GiB", 32'h38, 3'd4);
      // R8 link status
      link_up = 3'b101; do_read("R8 links", 32'h18, 3'd4);
      link_up = 3'b010; do_read("R8 links", 32'h18, 3'd4);
      // R2 partial accesses
      do_read("R2 partial read", 32'h14, 3'd2);
      do_read("R2 partial read", 32'h34, 3'd1);
      do_write("R2 partial write", 32'h10, 3'd2, 32'hFFFF_FFFF);
      // R9 read-only discards
      do_write("R9 ro write", 32'h14, 3'd4, 32'hFFFF_FFFF);
      do_read("R9 readback", 32'h14, 3'd4);
      do_write("R9 ro write", 32'h30, 3'd4, 32'h0);
      do_read("R9 readback", 32'h30, 3'd4);
      do_write("R9 ro write", 32'h38, 3'd4, 32'h0);
      do_read("R9 readback", 32'h38, 3'd4);
      // R10 reset pulse
      do_write("R10 bit4 set", 32'h10, 3'd4, 32'h0000_0010);
      do_write("R10 bit4 clear", 32'h10, 3'd4, 32'hFFFF_FFEF);
      // R12 idle cycle after read
      @(negedge clk);
      check("R12 idle", bus_rdata, 32'h0);
      // R11 undefined offsets and sticky flag
      do_read("R11 partial undef", 32'h4C, 3'd2);
      do_read("R11 undef", 32'h4C, 3'd4);
      do_write("R11 undef write", 32'h13, 3'd4, 32'hFFFF_FFFF);
      do_read("R11 unaligned", 32'h16, 3'd4);

      // random traffic (R2 R3 R5 R7 R8 R10 R11)
      for (int i = 0; i < 400; i++) begin
         logic [31:0] a;
         logic [2:0]  sz;
         a = {$urandom_range(0, 3) == 0 ? 16'($urandom) : 16'h0,
              16'($urandom_range(0, 'h60))};
         if ($urandom_range(0, 3) != 0) a[1:0] = 2'b00;
         sz = sizes[$urandom_range(0, 2)];
         timer_mhz = 8'($urandom);
         mem_gib = 8'($urandom_range(0, 15));
         link_up = 3'($urandom);
         if ($urandom_range(0, 1) == 0) do_read("R3 random read", a, sz);
         else do_write("R10 random write", a, sz, 32'($urandom));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule